// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel. A host-side loader hands it a 6-bit control word and, separately, a complete 16-bit initial count, each with a one-cycle strobe. The channel moves the count into its counting element and decrements it once for every timer-clock pulse. It drives one output pin whose waveform depends on the selected mode. The six modes are an interrupt on terminal count, a retriggerable one-shot, a rate generator, a square wave, and a software-triggered or gate-triggered strobe.

The timer clock (`tick`) and the gate are synchronous inputs sampled on the system clock. Counting can be binary or BCD. A loaded count of zero stands for the full range of the selected radix. A null-count flag reports whether a written count is still waiting to be moved into the counting element.

Top module: `pit_channel`

## Requirements
- R1: The control word is decoded as follows. Bit 0 selects BCD counting when it is 1. Bits 3:1 give the mode. When bit 2 is 1, only bits 2:1 are used, so codes 6 and 7 act as modes 2 and 3. The effective mode and the radix are shown on `eff_mode` and `bcd_mode`.
- R2: After reset the control register holds 0x30, which means mode 0 and binary counting. The counting element reads 0, `null_flag` is 1 and `tmr_out` is 0.
- R3: `null_flag` is set on the cycle after a control write or a count write. It is cleared on the tick on which the count is moved into the counting element.
- R4: A loaded count of 0 lasts 65536 ticks in binary and 10000 ticks in BCD.
- R5: In BCD, a nibble that steps down from 0 wraps to 9 and borrows from the next nibble. A nibble holding A to F steps down as in binary. The whole counter wraps from 0000 to 9999.
- R6: Mode 0: a control write or a count write drives the output low. The count is loaded on the next tick. The output goes high on the N-th tick after the load. The counting element holds while the gate is low.
- R7: Mode 1: a rising gate edge arms a trigger. The next tick loads the count and drives the output low. The output goes high N ticks later. A new edge before that reloads the count.
- R8: Mode 2: the output is low for one tick in every N ticks. The count register is reloaded at the end of each period, so a count written while running takes effect only at the next period.
- R9: Mode 3: the output is a square wave. It is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R10: Modes 2 and 3: a low gate forces the output high on the next cycle and stops the counting element. A rising gate edge reloads the count on the next tick.
- R11: Mode 4: the count is loaded on the tick after a count write, and the gate level enables counting. On the N-th enabled tick after the load the output is low for exactly one tick.
- R12: Mode 5: only a rising gate edge starts counting, and the gate level has no effect. The output strobes low for one tick, N ticks after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 6 | Control word |
| cnt_wr | input | 1 | Complete count write strobe |
| cnt_data | input | 16 | Initial count |
| tick | input | 1 | Timer-clock enable, one pulse per count |
| gate | input | 1 | Gate input |
| tmr_out | output | 1 | Timer output pin |
| null_flag | output | 1 | Written count not yet loaded |
| ce_value | output | 16 | Present counting-element value |
| eff_mode | output | 3 | Effective decoded mode, 0 to 5 |
| bcd_mode | output | 1 | BCD counting selected |

## Verification
A corrupted counting element shows up on `ce_value` at the next tick. It also shifts the output edge by however many ticks the value is off, so the edges are timed tick by tick against N. A wrong mode decode or a lost gate edge shows within one or two cycles: the output fails to fall, rise or hold at the expected tick. A stuck null-count flag is seen on the tick that should have loaded the count.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    PM_TC_INT    = 3'd0,
    PM_ONESHOT   = 3'd1,
    PM_RATE      = 3'd2,
    PM_SQUARE    = 3'd3,
    PM_SW_STROBE = 3'd4,
    PM_HW_STROBE = 3'd5
  } pit_mode_e;

  localparam logic [5:0] CTRL_RESET = 6'h30;

  // bit 2 set folds codes 6/7 onto 2/3
  function automatic pit_mode_e decode_mode(input logic [5:0] cw);
    if (cw[2]) decode_mode = pit_mode_e'({1'b0, cw[2:1]});
    else       decode_mode = pit_mode_e'(cw[3:1]);
  endfunction

endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [5:0] data_i,
  output pit_mode_e  mode_o,
  output logic       bcd_o
);

  logic [5:0] ctrl_q;
  logic [5:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

  assign mode_o = decode_mode(ctrl_q);
  assign bcd_o  = ctrl_q[0];

endmodule

// File: rtl/pit_gate_sense.sv
module pit_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/pit_count_arith.sv
module pit_count_arith #(
  parameter int CW = 16,
  localparam int NIB = CW / 4,
  localparam int PW = CW + 1
) (
  input  logic          bcd_i,
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] dec_o,
  output logic [PW-1:0] period_o
);

  logic [NIB:0] borrow;
  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    logic [3:0] nib;
    assign nib           = val_i[4*g +: 4];
    assign borrow[g+1]   = borrow[g] & (nib == 4'd0);
    assign dec_o[4*g +: 4] = !borrow[g] ? nib :
                             (nib == 4'd0) ? (bcd_i ? 4'd9 : 4'hF) : nib - 4'd1;
  end

  // number of ticks one full load of reload_i lasts
  always_comb begin
    logic [PW-1:0] acc;
    logic [PW-1:0] weight;
    acc    = '0;
    weight = PW'(1);
    for (int i = 0; i < NIB; i++) begin
      acc    = acc + (PW'(reload_i[4*i +: 4]) * weight);
      weight = weight * PW'(10);
    end
    if (!bcd_i)
      period_o = (reload_i == '0) ? (PW'(1) << CW) : PW'(reload_i);
    else
      period_o = (reload_i == '0) ? weight : acc;
  end

  function automatic logic all_decimal(input logic [CW-1:0] v);
    all_decimal = 1'b1;
    for (int i = 0; i < NIB; i++)
      if (v[4*i +: 4] > 4'd9) all_decimal = 1'b0;
  endfunction

  always_comb begin
    if (bcd_i && all_decimal(val_i))
      AST_BCD_LEGAL: assert (all_decimal(dec_o)) else $error("BCD digit left range"); // R5
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16,
  localparam int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [5:0]    ctrl_data,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_data,
  input  logic          tick,
  input  logic          gate,
  output logic          tmr_out,
  output logic          null_flag,
  output logic [CW-1:0] ce_value,
  output logic [2:0]    eff_mode,
  output logic          bcd_mode
);

  pit_mode_e     mode;
  logic          bcd;
  logic          gate_rise;
  logic [CW-1:0] ce_dec;
  logic [PW-1:0] period;
  logic [PW-1:0] half_hi, half_lo;

  logic [CW-1:0] cr_q, cr_d;
  logic [CW-1:0] ce_q, ce_d;
  logic [PW-1:0] hcnt_q, hcnt_d;
  logic          out_q, out_d;
  logic          null_q, null_d;
  logic          run_q, run_d;
  logic          pend_q, pend_d;
  logic          trig_q, trig_d;
  logic          crv_q, crv_d;
  logic          fired_q, fired_d;
  logic          count_en;

  pit_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ctrl_wr),
    .data_i (ctrl_data),
    .mode_o (mode),
    .bcd_o  (bcd)
  );

  pit_gate_sense u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  pit_count_arith #(.CW(CW)) u_arith (
    .bcd_i    (bcd),
    .val_i    (ce_q),
    .reload_i (cr_q),
    .dec_o    (ce_dec),
    .period_o (period)
  );

  assign half_hi = (period + PW'(1)) >> 1;
  assign half_lo = period >> 1;

  always_comb begin
    case (mode)
      PM_ONESHOT, PM_HW_STROBE: count_en = 1'b1;
      default:                  count_en = gate;
    endcase
  end

  always_comb begin
    cr_d    = cr_q;
    ce_d    = ce_q;
    hcnt_d  = hcnt_q;
    out_d   = out_q;
    null_d  = null_q;
    run_d   = run_q;
    pend_d  = pend_q;
    trig_d  = trig_q;
    crv_d   = crv_q;
    fired_d = fired_q;
    if (ctrl_wr) begin
      null_d  = 1'b1;
      run_d   = 1'b0;
      pend_d  = 1'b0;
      trig_d  = 1'b0;
      crv_d   = 1'b0;
      fired_d = 1'b0;
      out_d   = (decode_mode(ctrl_data) == PM_TC_INT) ? 1'b0 : 1'b1;
    end else begin
      if (cnt_wr) begin
        cr_d   = cnt_data;
        null_d = 1'b1;
        crv_d  = 1'b1;
        case (mode)
          PM_TC_INT: begin
            pend_d = 1'b1;
            run_d  = 1'b0;
            out_d  = 1'b0;
          end
          PM_SW_STROBE: begin
            pend_d  = 1'b1;
            run_d   = 1'b0;
            fired_d = 1'b0;
          end
          PM_RATE, PM_SQUARE: if (!run_q) pend_d = 1'b1;
          default: ;
        endcase
      end
      if (gate_rise && crv_q && (mode inside {PM_ONESHOT, PM_RATE, PM_SQUARE, PM_HW_STROBE}))
        trig_d = 1'b1;
      if (tick && !cnt_wr) begin
        if ((mode inside {PM_SW_STROBE, PM_HW_STROBE}) && !out_q)
          out_d = 1'b1;
        if (pend_q || trig_q) begin
          ce_d    = cr_q;
          null_d  = 1'b0;
          run_d   = 1'b1;
          pend_d  = 1'b0;
          trig_d  = 1'b0;
          fired_d = 1'b0;
          hcnt_d  = half_hi;
          out_d   = (mode inside {PM_TC_INT, PM_ONESHOT}) ? 1'b0 : 1'b1;
        end else if (run_q && count_en) begin
          case (mode)
            PM_TC_INT, PM_ONESHOT: begin
              ce_d = ce_dec;
              if (ce_q == CW'(1)) out_d = 1'b1;
            end
            PM_RATE: begin
              if (ce_q == CW'(1)) begin
                ce_d   = cr_q;
                null_d = 1'b0;
                out_d  = 1'b1;
              end else begin
                ce_d = ce_dec;
                if (ce_q == CW'(2)) out_d = 1'b0;
              end
            end
            PM_SQUARE: begin
              ce_d = ce_dec;
              if (hcnt_q == PW'(1)) begin
                if (out_q) begin
                  out_d  = 1'b0;
                  hcnt_d = (half_lo == '0) ? PW'(1) : half_lo;
                end else begin
                  out_d  = 1'b1;
                  hcnt_d = half_hi;
                  ce_d   = cr_q;
                  null_d = 1'b0;
                end
              end else begin
                hcnt_d = hcnt_q - PW'(1);
              end
            end
            default: begin
              ce_d = ce_dec;
              if (ce_q == CW'(1) && !fired_q) begin
                out_d   = 1'b0;
                fired_d = 1'b1;
              end
            end
          endcase
        end
      end
      if ((mode inside {PM_RATE, PM_SQUARE}) && !gate)
        out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q    <= '0;
      ce_q    <= '0;
      hcnt_q  <= '0;
      out_q   <= 1'b0;
      null_q  <= 1'b1;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      crv_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      cr_q    <= cr_d;
      ce_q    <= ce_d;
      hcnt_q  <= hcnt_d;
      out_q   <= out_d;
      null_q  <= null_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
      trig_q  <= trig_d;
      crv_q   <= crv_d;
      fired_q <= fired_d;
    end
  end

  assign tmr_out   = out_q;
  assign null_flag = null_q;
  assign ce_value  = ce_q;
  assign eff_mode  = mode;
  assign bcd_mode  = bcd;

  AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr || cnt_wr) |=> null_flag); // R3

  AST_MODE0_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[3:1] == 3'd0) |=> !tmr_out); // R6

  AST_GATE_LOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode inside {PM_RATE, PM_SQUARE}) && !gate && !ctrl_wr) |=> tmr_out); // R10

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SW_STROBE && !gate && !ctrl_wr && !cnt_wr && !pend_q) |=> $stable(ce_value)); // R11

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode inside {PM_SW_STROBE, PM_HW_STROBE}) && !tmr_out && tick && !ctrl_wr && !cnt_wr)
    |=> tmr_out); // R12

endmodule

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [5:0]  ctrl_data;
  logic        cnt_wr;
  logic [15:0] cnt_data;
  logic        tick;
  logic        gate;
  logic        tmr_out;
  logic        null_flag;
  logic [15:0] ce_value;
  logic [2:0]  eff_mode;
  logic        bcd_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel u_pit_channel (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_data (ctrl_data),
    .cnt_wr    (cnt_wr),
    .cnt_data  (cnt_data),
    .tick      (tick),
    .gate      (gate),
    .tmr_out   (tmr_out),
    .null_flag (null_flag),
    .ce_value  (ce_value),
    .eff_mode  (eff_mode),
    .bcd_mode  (bcd_mode)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] d);
    ctrl_data = d; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] d);
    cnt_data = d; cnt_wr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 out", tmr_out, 0);
    chk("R2 null", null_flag, 1);
    chk("R2 ce", ce_value, 0);
    chk("R2 mode", eff_mode, 0);
    chk("R2 bcd", bcd_mode, 0);
  endtask

  task automatic t_decode();
    wr_ctrl(6'h3C); chk("R1 code6->2", eff_mode, 2);
    chk("R3 null after ctrl", null_flag, 1);
    wr_ctrl(6'h3E); chk("R1 code7->3", eff_mode, 3);
    wr_ctrl(6'h3B); chk("R1 mode5", eff_mode, 5); chk("R1 bcd", bcd_mode, 1);
    wr_ctrl(6'h31); chk("R1 mode0", eff_mode, 0); chk("R1 bcd0", bcd_mode, 1);
  endtask

  task automatic t_mode0();
    set_gate(1'b1);
    wr_ctrl(6'h30); chk("R6 ctrl low", tmr_out, 0);
    wr_cnt(16'd5);  chk("R3 null on count", null_flag, 1);
    ticks(1); chk("R6 load ce", ce_value, 5); chk("R3 null cleared", null_flag, 0);
    ticks(4); chk("R6 ce 1", ce_value, 1); chk("R6 still low", tmr_out, 0);
    set_gate(1'b0); ticks(3); chk("R6 gate hold", ce_value, 1);
    set_gate(1'b1); ticks(1); chk("R6 tc high", tmr_out, 1); chk("R6 ce 0", ce_value, 0);
  endtask

  task automatic t_zero_bin();
    wr_ctrl(6'h30); wr_cnt(16'h0000);
    ticks(1); chk("R4 bin load", ce_value, 0);
    ticks(65535); chk("R4 bin ce", ce_value, 1); chk("R4 bin low", tmr_out, 0);
    ticks(1); chk("R4 bin high at 65536", tmr_out, 1);
  endtask

  task automatic t_zero_bcd();
    wr_ctrl(6'h31); wr_cnt(16'h0000);
    ticks(1);
    ticks(1); chk("R5 wrap 9999", ce_value, 16'h9999);
    ticks(9998); chk("R4 bcd ce", ce_value, 1); chk("R4 bcd low", tmr_out, 0);
    ticks(1); chk("R4 bcd high at 10000", tmr_out, 1);
  endtask

  task automatic t_bcd_nibble();
    wr_ctrl(6'h31); wr_cnt(16'h00A0);
    ticks(1); ticks(1); chk("R5 A0 step", ce_value, 16'h0099);
    wr_cnt(16'h0B10);
    ticks(1); ticks(1); chk("R5 B10 step", ce_value, 16'h0B09);
  endtask

  task automatic t_mode1();
    set_gate(1'b1);
    wr_ctrl(6'h32); chk("R7 idle high", tmr_out, 1);
    wr_cnt(16'd3); ticks(2); chk("R7 no trigger", tmr_out, 1);
    set_gate(1'b0); set_gate(1'b1);
    ticks(1); chk("R7 trig low", tmr_out, 0); chk("R7 trig ce", ce_value, 3);
    ticks(2); chk("R7 ce 1", ce_value, 1);
    set_gate(1'b0); set_gate(1'b1);
    ticks(1); chk("R7 retrigger ce", ce_value, 3); chk("R7 retrigger low", tmr_out, 0);
    ticks(2); chk("R7 before tc", tmr_out, 0);
    ticks(1); chk("R7 tc high", tmr_out, 1);
  endtask

  task automatic t_mode2();
    set_gate(1'b1);
    wr_ctrl(6'h34); wr_cnt(16'd4);
    ticks(1); chk("R8 load", ce_value, 4);
    ticks(2); chk("R8 high", tmr_out, 1);
    ticks(1); chk("R8 pulse low", tmr_out, 0);
    ticks(1); chk("R8 reload high", tmr_out, 1); chk("R8 reload ce", ce_value, 4);
    wr_cnt(16'd3); chk("R3 pending", null_flag, 1);
    ticks(3); chk("R8 old period low", tmr_out, 0); chk("R3 still pending", null_flag, 1);
    ticks(1); chk("R8 new count", ce_value, 3); chk("R3 cleared on reload", null_flag, 0);
  endtask

  task automatic t_mode3();
    int n;
    set_gate(1'b1);
    wr_ctrl(6'h36); wr_cnt(16'd5);
    ticks(1); chk("R9 load high", tmr_out, 1);
    n = 0;
    while (tmr_out == 1'b1 && n < 20) begin ticks(1); n++; end
    chk("R9 high ticks", n, 3);
    n = 0;
    while (tmr_out == 1'b0 && n < 20) begin ticks(1); n++; end
    chk("R9 low ticks", n, 2);
    ticks(3); chk("R9 low again", tmr_out, 0);
    set_gate(1'b0); chk("R10 forced high", tmr_out, 1);
    n = ce_value;
    ticks(3); chk("R10 held", ce_value, n); chk("R10 stays high", tmr_out, 1);
    set_gate(1'b1);
    ticks(1); chk("R10 rise reload", ce_value, 5);
  endtask

  task automatic t_mode4();
    set_gate(1'b1);
    wr_ctrl(6'h38); wr_cnt(16'd3);
    ticks(1); chk("R11 load", ce_value, 3);
    set_gate(1'b0); ticks(5); chk("R11 gate stops", ce_value, 3);
    set_gate(1'b1); ticks(2); chk("R11 ce 1", ce_value, 1); chk("R11 high", tmr_out, 1);
    ticks(1); chk("R11 strobe", tmr_out, 0);
    ticks(1); chk("R11 one tick", tmr_out, 1);
  endtask

  task automatic t_mode5();
    wr_ctrl(6'h3A); wr_cnt(16'd3);
    ticks(2); chk("R12 no start", null_flag, 1);
    set_gate(1'b0); set_gate(1'b1); set_gate(1'b0);
    ticks(1); chk("R12 load", ce_value, 3); chk("R12 null", null_flag, 0);
    ticks(2); chk("R12 level ignored", ce_value, 1); chk("R12 high", tmr_out, 1);
    ticks(1); chk("R12 strobe", tmr_out, 0);
    ticks(1); chk("R12 one tick", tmr_out, 1);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_data = '0; cnt_wr = 1'b0;
    cnt_data = '0; tick = 1'b0; gate = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_mode0();
    t_zero_bin();
    t_zero_bcd();
    t_bcd_nibble();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule